// File: doc/BRIEF.md
# RV64 Word-Operation Execute Unit

This unit decodes and executes the 64-bit immediate shifts and the 32-bit "word" arithmetic and shift operations of a 64-bit RISC-V integer core. Each cycle it may accept one instruction word together with the two source register values. One clock later it presents the destination register index, the 64-bit result, a write enable for the register file and a flag that marks encodings this unit does not execute.

Word operations work only on the low 32 bits of their operands. A register-sourced shift count keeps only its low five bits. The 32-bit result is then widened to 64 bits by copying its bit 31 into the upper half. The doubleword immediate shifts work on the full register and take a six-bit shift amount.

Top module: `wexu_top`

## Requirements
- R1: An instruction sampled with `inValid` high gives `outValid` high on the next clock edge, with its results. While `outValid` is low, `writeEn` and `illegal` are low. Back-to-back instructions each produce one output in order.
- R2: Opcode 0010011 with funct3 001 and bits 31:26 equal to 000000 shifts all 64 bits of rs1 left by the amount in bits 25:20.
- R3: Opcode 0010011 with funct3 101 shifts all 64 bits of rs1 right by bits 25:20. Bits 31:26 = 000000 gives a logical shift. Bits 31:26 = 010000 gives an arithmetic shift that replicates bit 63.
- R4: Opcode 0011011 with funct3 000 adds the sign-extended 12-bit immediate in bits 31:20 to the low 32 bits of rs1, wrapping at 32 bits.
- R5: Opcode 0011011 shifts the low 32 bits of rs1 by the five-bit amount in bits 24:20. Funct3 001 with funct7 0000000 shifts left. Funct3 101 with funct7 0000000 shifts right logically. Funct3 101 with funct7 0100000 shifts right arithmetically and replicates bit 31, not bit 63.
- R6: Opcode 0111011 with funct3 000 adds (funct7 0000000) or subtracts rs2 from rs1 (funct7 0100000), using the low 32 bits of each and wrapping at 32 bits.
- R7: Opcode 0111011 with funct3 001 or 101 shifts the low 32 bits of rs1 by rs2 bits 4:0. The funct7 rules are the same as in R5, and the upper bits of rs2 have no effect.
- R8: For every word operation, bits 63:32 of the result equal bit 31 of the result.
- R9: `destIdx` carries instruction bits 11:7. `writeEn` is low when that index is 0, even though the result is still produced.
- R10: These encodings raise `illegal`, drive `writeEn` low and give a zero result: any other opcode, any other funct3, any other funct7 or upper-six-bit pattern, and an immediate word shift with bit 25 set.
- R11: During reset `outValid`, `writeEn` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| srcA | input | XLEN | Value of rs1 |
| srcB | input | XLEN | Value of rs2 |
| outValid | output | 1 | Registered result present |
| destIdx | output | 5 | Destination register index |
| result | output | XLEN | Registered 64-bit result |
| writeEn | output | 1 | Register-file write request |
| illegal | output | 1 | Encoding not executed by this unit |

## Verification
The unit has a single register stage, so a wrong decode or a wrong operand selection shows up on `result`, `writeEn` or `illegal` exactly one cycle after the instruction. The operand values are chosen so that each likely fault gives a different visible value. A shift count that is not masked, or a sign taken from bit 63 instead of bit 31, changes the upper half of the result. A wrong destination check shows up as a spurious write to register 0. A lost or duplicated output stage leaves the expected-item queue uneven at the end of the run.

// File: rtl/wexu_pkg.sv
package wexu_pkg;
  typedef enum logic [2:0] {OP_ADD, OP_SUB, OP_SLL, OP_SRL, OP_SRA} aluOp_e;

  typedef struct packed {
    logic   valid;
    aluOp_e op;
    logic   isWord;
    logic   useImm;
    logic   illegal;
    logic   wen;
  } ctrlStrb_t;

  localparam logic [6:0] OPC_SHIFT64 = 7'b0010011;
  localparam logic [6:0] OPC_IMMW    = 7'b0011011;
  localparam logic [6:0] OPC_REGW    = 7'b0111011;
  localparam logic [2:0] F3_ADD      = 3'b000;
  localparam logic [2:0] F3_SL       = 3'b001;
  localparam logic [2:0] F3_SR       = 3'b101;
  localparam logic [6:0] F7_BASE     = 7'b0000000;
  localparam logic [6:0] F7_ALT      = 7'b0100000;
  localparam logic [5:0] U6_BASE     = 6'b000000;
  localparam logic [5:0] U6_ALT      = 6'b010000;
endpackage

// File: rtl/wexu_ctrl.sv
module wexu_ctrl
  import wexu_pkg::*;
(
  input  logic        inValid,
  input  logic [31:0] instr,
  output ctrlStrb_t   strb
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic [5:0] upper6;
  logic [4:0] rdIdx;
  aluOp_e     op;
  logic       isWord;
  logic       useImm;
  logic       bad;

  assign opc    = instr[6:0];
  assign f3     = instr[14:12];
  assign f7     = instr[31:25];
  assign upper6 = instr[31:26];
  assign rdIdx  = instr[11:7];

  always_comb begin
    op     = OP_ADD;
    isWord = 1'b0;
    useImm = 1'b0;
    bad    = 1'b0;
    case (opc)
      OPC_SHIFT64: begin
        useImm = 1'b1;
        if (f3 == F3_SL && upper6 == U6_BASE)      op = OP_SLL;
        else if (f3 == F3_SR && upper6 == U6_BASE) op = OP_SRL;
        else if (f3 == F3_SR && upper6 == U6_ALT)  op = OP_SRA;
        else                                        bad = 1'b1;
      end
      OPC_IMMW: begin
        useImm = 1'b1;
        isWord = 1'b1;
        if (f3 == F3_ADD)                          op = OP_ADD;
        else if (f3 == F3_SL && f7 == F7_BASE)     op = OP_SLL;
        else if (f3 == F3_SR && f7 == F7_BASE)     op = OP_SRL;
        else if (f3 == F3_SR && f7 == F7_ALT)      op = OP_SRA;
        else                                        bad = 1'b1;
      end
      OPC_REGW: begin
        isWord = 1'b1;
        if (f3 == F3_ADD && f7 == F7_BASE)         op = OP_ADD;
        else if (f3 == F3_ADD && f7 == F7_ALT)     op = OP_SUB;
        else if (f3 == F3_SL && f7 == F7_BASE)     op = OP_SLL;
        else if (f3 == F3_SR && f7 == F7_BASE)     op = OP_SRL;
        else if (f3 == F3_SR && f7 == F7_ALT)      op = OP_SRA;
        else                                        bad = 1'b1;
      end
      default: bad = 1'b1;
    endcase
  end

  always_comb begin
    strb.valid   = inValid;
    strb.op      = op;
    strb.isWord  = isWord;
    strb.useImm  = useImm;
    strb.illegal = inValid & bad;
    strb.wen     = inValid & ~bad & (rdIdx != 5'd0);
  end
endmodule

// File: rtl/wexu_dp.sv
module wexu_dp
  import wexu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WORD = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrb_t       strb,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  output logic            outValid,
  output logic [4:0]      destIdx,
  output logic [XLEN-1:0] result,
  output logic            writeEn,
  output logic            illegal
);
  localparam int SH_W  = $clog2(XLEN);
  localparam int WSH_W = $clog2(WORD);
  localparam int IMM_W = 12;

  logic [XLEN-1:0]  immExt;
  logic [XLEN-1:0]  opB;
  logic [SH_W-1:0]  shamt;
  logic [WSH_W-1:0] wordAmt;
  logic [WORD-1:0]  wordA;
  logic [WORD-1:0]  wordB;
  logic [WORD-1:0]  wordRes;
  logic [XLEN-1:0]  fullRes;
  logic [XLEN-1:0]  nextResult;
  logic             wordOut;

  assign immExt  = {{(XLEN-IMM_W){instr[31]}}, instr[31:20]};
  assign opB     = strb.useImm ? immExt : srcB;
  assign shamt   = strb.useImm ? instr[20+SH_W-1:20] : srcB[SH_W-1:0];
  assign wordAmt = shamt[WSH_W-1:0];
  assign wordA   = srcA[WORD-1:0];
  assign wordB   = opB[WORD-1:0];

  always_comb begin
    case (strb.op)
      OP_ADD:  wordRes = wordA + wordB;
      OP_SUB:  wordRes = wordA - wordB;
      OP_SLL:  wordRes = wordA << wordAmt;
      OP_SRL:  wordRes = wordA >> wordAmt;
      OP_SRA:  wordRes = $signed(wordA) >>> wordAmt;
      default: wordRes = '0;
    endcase
  end

  always_comb begin
    case (strb.op)
      OP_SLL:  fullRes = srcA << shamt;
      OP_SRL:  fullRes = srcA >> shamt;
      OP_SRA:  fullRes = $signed(srcA) >>> shamt;
      default: fullRes = '0;
    endcase
  end

  always_comb begin
    if (strb.illegal)     nextResult = '0;
    else if (strb.isWord) nextResult = {{(XLEN-WORD){wordRes[WORD-1]}}, wordRes};
    else                  nextResult = fullRes;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      writeEn  <= 1'b0;
      illegal  <= 1'b0;
      wordOut  <= 1'b0;
      destIdx  <= '0;
      result   <= '0;
    end else begin
      outValid <= strb.valid;
      writeEn  <= strb.wen;
      illegal  <= strb.illegal;
      wordOut  <= strb.valid & strb.isWord & ~strb.illegal;
      if (strb.valid) begin
        destIdx <= instr[11:7];
        result  <= nextResult;
      end
    end
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.valid |=> outValid);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!writeEn && !illegal));
  // R8
  word_sext_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordOut |-> (result[XLEN-1:WORD] == {(XLEN-WORD){result[WORD-1]}}));
  // R9
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && destIdx == 5'd0) |-> !writeEn);
  // R10
  illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!writeEn && result == '0));
endmodule

// File: rtl/wexu_top.sv
module wexu_top #(
  parameter int XLEN = 64,
  parameter int WORD = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  output logic            outValid,
  output logic [4:0]      destIdx,
  output logic [XLEN-1:0] result,
  output logic            writeEn,
  output logic            illegal
);
  wexu_pkg::ctrlStrb_t strb;

  wexu_ctrl i_ctrl (
    .inValid (inValid),
    .instr   (instr),
    .strb    (strb)
  );

  wexu_dp #(.XLEN(XLEN), .WORD(WORD)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .instr    (instr),
    .srcA     (srcA),
    .srcB     (srcB),
    .outValid (outValid),
    .destIdx  (destIdx),
    .result   (result),
    .writeEn  (writeEn),
    .illegal  (illegal)
  );
endmodule

// File: tb/test_wexu_top.sv
`timescale 1ns/1ps
module test_wexu_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic        outValid;
  logic [4:0]  destIdx;
  logic [63:0] result;
  logic        writeEn;
  logic        illegal;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  typedef struct {
    string       tag;
    logic [4:0]  rd;
    logic [63:0] res;
    bit          wen;
    bit          ill;
  } expItem_t;
  expItem_t sbQ[$];

  always #4 clk = ~clk;

  wexu_top i_wexu_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
    .srcA(srcA), .srcB(srcB), .outValid(outValid), .destIdx(destIdx),
    .result(result), .writeEn(writeEn), .illegal(illegal)
  );

  function automatic logic [31:0] encR(logic [6:0] f7, logic [4:0] rs2,
      logic [4:0] rs1, logic [2:0] f3, logic [4:0] rd, logic [6:0] opc);
    return {f7, rs2, rs1, f3, rd, opc};
  endfunction

  function automatic logic [31:0] encI(logic [11:0] imm, logic [4:0] rs1,
      logic [2:0] f3, logic [4:0] rd, logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  task automatic send(string tag, logic [31:0] ins, logic [63:0] a,
      logic [63:0] b, logic [63:0] expRes, bit expIll);
    expItem_t it;
    @(negedge clk);
    inValid = 1'b1;
    instr   = ins;
    srcA    = a;
    srcB    = b;
    it.tag = tag;
    it.rd  = ins[11:7];
    it.res = expRes;
    it.ill = expIll;
    it.wen = !expIll && (ins[11:7] != 5'd0);
    sbQ.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      srcA    = 64'hDEAD_BEEF_DEAD_BEEF;
    end
  endtask

  // monitor: pops one expected item per produced output
  always @(negedge clk) begin
    if (rstN && outValid) begin
      checkCnt++;
      if (sbQ.size() == 0) begin
        failCnt++;
        $display("FAIL R1 unexpected output: got res=%h expected none", result);
      end else begin
        expItem_t e;
        e = sbQ.pop_front();
        if (result !== e.res || writeEn !== e.wen || illegal !== e.ill ||
            destIdx !== e.rd) begin
          failCnt++;
          $display("FAIL %s: got rd=%0d res=%h wen=%b ill=%b expected rd=%0d res=%h wen=%b ill=%b",
                   e.tag, destIdx, result, writeEn, illegal, e.rd, e.res, e.wen, e.ill);
        end
      end
    end
  end

  task automatic quietCheck(string tag);
    @(negedge clk);
    #1;
    checkCnt++;
    if (outValid !== 1'b0 || writeEn !== 1'b0 || illegal !== 1'b0) begin
      failCnt++;
      $display("FAIL %s: got valid=%b wen=%b ill=%b expected 0 0 0",
               tag, outValid, writeEn, illegal);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R11 reset state
    repeat (3) @(posedge clk);
    quietCheck("R11 reset");
    @(negedge clk) rstN = 1'b1;

    // R2 64-bit left shift, amount 33
    send("R2 slli", encI({6'b000000, 6'd33}, 5'd1, 3'b001, 5'd5, 7'b0010011),
         64'h0000_0000_8000_0001, 64'h0, 64'h0000_0002_0000_0000, 1'b0);
    // R3 logical and arithmetic 64-bit right shifts
    send("R3 srli", encI({6'b000000, 6'd63}, 5'd1, 3'b101, 5'd6, 7'b0010011),
         64'h8000_0000_0000_0000, 64'h0, 64'h1, 1'b0);
    send("R3 srai4", encI({6'b010000, 6'd4}, 5'd1, 3'b101, 5'd7, 7'b0010011),
         64'hF000_0000_0000_0000, 64'h0, 64'hFF00_0000_0000_0000, 1'b0);
    send("R3 srai36", encI({6'b010000, 6'd36}, 5'd1, 3'b101, 5'd8, 7'b0010011),
         64'h8000_0000_0000_0000, 64'h0, 64'hFFFF_FFFF_F800_0000, 1'b0);
    idle(2);
    // R1 outputs quiet between bursts
    quietCheck("R1 idle");

    // R4 add immediate word
    send("R4 addiw neg", encI(12'hFFF, 5'd2, 3'b000, 5'd9, 7'b0011011),
         64'h1234_5678_0000_0000, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    send("R4 R8 addiw wrap", encI(12'h001, 5'd2, 3'b000, 5'd10, 7'b0011011),
         64'h0000_0000_7FFF_FFFF, 64'h0, 64'hFFFF_FFFF_8000_0000, 1'b0);
    send("R4 addiw pos", encI(12'h7FF, 5'd2, 3'b000, 5'd11, 7'b0011011),
         64'hFFFF_FFFF_0000_0001, 64'h0, 64'h0000_0000_0000_0800, 1'b0);
    // R5 immediate word shifts
    send("R5 slliw", encI({7'b0000000, 5'd31}, 5'd3, 3'b001, 5'd12, 7'b0011011),
         64'h1, 64'h0, 64'hFFFF_FFFF_8000_0000, 1'b0);
    send("R5 srliw", encI({7'b0000000, 5'd4}, 5'd3, 3'b101, 5'd13, 7'b0011011),
         64'hFFFF_FFFF_8000_0000, 64'h0, 64'h0000_0000_0800_0000, 1'b0);
    send("R5 sraiw neg", encI({7'b0100000, 5'd4}, 5'd3, 3'b101, 5'd14, 7'b0011011),
         64'h0000_0000_8000_0000, 64'h0, 64'hFFFF_FFFF_F800_0000, 1'b0);
    send("R5 sraiw bit31", encI({7'b0100000, 5'd4}, 5'd3, 3'b101, 5'd15, 7'b0011011),
         64'hFFFF_FFFF_7000_0000, 64'h0, 64'h0000_0000_0700_0000, 1'b0);
    idle(1);

    // R6 register add and subtract
    send("R6 addw wrap", encR(7'b0000000, 5'd4, 5'd5, 3'b000, 5'd16, 7'b0111011),
         64'h0000_0000_FFFF_FFFF, 64'h1, 64'h0, 1'b0);
    send("R6 subw", encR(7'b0100000, 5'd4, 5'd5, 3'b000, 5'd17, 7'b0111011),
         64'h0000_0001_0000_0000, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    send("R6 R8 addw sign", encR(7'b0000000, 5'd4, 5'd5, 3'b000, 5'd18, 7'b0111011),
         64'h0000_0000_4000_0000, 64'hAAAA_0000_4000_0000, 64'hFFFF_FFFF_8000_0000, 1'b0);
    // R7 register word shifts, count masked to 5 bits
    send("R7 sllw", encR(7'b0000000, 5'd4, 5'd5, 3'b001, 5'd19, 7'b0111011),
         64'h1, 64'hFFFF_FFFF_FFFF_FFE1, 64'h2, 1'b0);
    send("R7 srlw", encR(7'b0000000, 5'd4, 5'd5, 3'b101, 5'd20, 7'b0111011),
         64'h0000_0000_8000_0000, 64'h3F, 64'h1, 1'b0);
    send("R7 sraw mask", encR(7'b0100000, 5'd4, 5'd5, 3'b101, 5'd21, 7'b0111011),
         64'h0000_0000_8000_0000, 64'h20, 64'hFFFF_FFFF_8000_0000, 1'b0);

    // R9 destination zero: result produced, no write
    send("R9 addw rd0", encR(7'b0000000, 5'd4, 5'd5, 3'b000, 5'd0, 7'b0111011),
         64'h5, 64'h6, 64'hB, 1'b0);
    send("R9 addiw rd0", encI(12'h003, 5'd2, 3'b000, 5'd0, 7'b0011011),
         64'h7, 64'h0, 64'hA, 1'b0);

    // R10 unsupported encodings
    send("R10 slliw bit25", encI({7'b0000001, 5'd3}, 5'd3, 3'b001, 5'd22, 7'b0011011),
         64'h1, 64'h0, 64'h0, 1'b1);
    send("R10 addw f7", encR(7'b0000001, 5'd4, 5'd5, 3'b000, 5'd23, 7'b0111011),
         64'h1, 64'h1, 64'h0, 1'b1);
    send("R10 opcode", encR(7'b0000000, 5'd4, 5'd5, 3'b000, 5'd24, 7'b0110011),
         64'h1, 64'h1, 64'h0, 1'b1);
    send("R10 slli upper6", encI({6'b000001, 6'd2}, 5'd1, 3'b001, 5'd25, 7'b0010011),
         64'h1, 64'h0, 64'h0, 1'b1);
    send("R10 immw f3", encI(12'h001, 5'd2, 3'b010, 5'd26, 7'b0011011),
         64'h1, 64'h0, 64'h0, 1'b1);
    send("R10 sllw alt f7", encR(7'b0100000, 5'd4, 5'd5, 3'b001, 5'd27, 7'b0111011),
         64'h1, 64'h1, 64'h0, 1'b1);
    send("R10 rd0 illegal", encR(7'b0000011, 5'd4, 5'd5, 3'b101, 5'd0, 7'b0111011),
         64'h1, 64'h1, 64'h0, 1'b1);
    idle(3);
    quietCheck("R1 drain");

    // R1 every instruction produced exactly one output
    checkCnt++;
    if (sbQ.size() != 0) begin
      failCnt++;
      $display("FAIL R1 pending outputs: got %0d left expected 0", sbQ.size());
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule